// File: doc/BRIEF.md
# Programmable Binary Stage-Select Timer

This block is a 24-stage binary counter with a selectable output tap. It advances once for each falling edge of a slow count input. That input is sampled in the system clock domain, passed through a two-flop synchronizer and turned into a one-cycle falling-edge strobe. A 4-bit select code and a skip input together choose which stage drives the single output `tap_out`. A designer uses the block as a programmable power-of-two divider, or as an interval timer that is started by a reset or set pulse.

The controls work as follows. `force_lo` clears the chain and holds the output low. `force_hi` clears the chain and latches the output high. After `force_hi` falls, the output drops at the first falling edge of the count input, and counting starts on the second. `hold` freezes the count while the source keeps running. `osc_stop` blocks the count source in the same way. When the skip input, `force_hi` and `force_lo` are all high, the chain splits into three 8-stage sections that count in parallel. This test mode fills every stage with ones quickly.

A controller with five states governs the block:
- ST_CLEAR: the chain is cleared and the output is low. This is the state at system reset and while `force_lo` is high.
- ST_FORCED: `force_hi` alone is high. The chain is cleared and the output is high.
- ST_WAKE: `force_hi` has been released. The output stays high until the first count strobe.
- ST_RUN: normal serial counting.
- ST_TEST: the three sections count in parallel.

Transitions, evaluated on every clock in this order of priority:
- Any state goes to ST_TEST when the test request is high. The test request is the skip input, `force_hi` and `force_lo` all high.
- Any state goes to ST_CLEAR when `force_lo` is high.
- Any state goes to ST_FORCED when `force_hi` is high.
- Without those controls: ST_CLEAR goes to ST_RUN, ST_FORCED goes to ST_WAKE, ST_WAKE goes to ST_RUN on a strobe, and ST_TEST goes to ST_RUN.

Top module: `stage_tap_timer`

## Requirements
- R1: The chain advances by exactly one for each falling edge of `cnt_in`. A rising edge, or a level held for many clocks, adds nothing.
- R2: With `skip_low`=0, select code k (0..15) drives stage 9+k to `tap_out`. Stage 1 is the least significant bit. After n counted edges from zero, the output equals bit (8+k) of n.
- R3: With `skip_low`=1, edges enter at stage 9 and stages 1..8 hold their value. Code k then gives bit k of the count n, which divides the input by 2^(k+1) with a 50% duty cycle.
- R4: A clock edge with `force_lo`=1 (and no test request) clears every stage and makes `tap_out` 0 from the next cycle on. System reset does the same.
- R5: A clock edge with `force_hi`=1 and `force_lo`=0 clears every stage and makes `tap_out` 1 from the next cycle on. The output stays 1 after release until the first falling edge. That edge drives the output low without counting, and the second edge counts.
- R6: While `hold`=1, falling edges do not change the count. After `hold` falls, the next falling edge counts.
- R7: While `osc_stop`=1, falling edges do not change the count.
- R8: When `skip_low`, `force_hi` and `force_lo` are all 1, the chain is cleared once and then counts as three parallel 8-stage sections with `tap_out` low. After 255 edges every stage is 1.
- R9: Dropping `force_hi` and `force_lo` in the same cycle leaves test mode with the count kept, in serial mode. One more edge with `skip_low`=0 rolls the chain from all ones to all zeros.
- R10: When `force_hi` and `force_lo` are both 1 while `skip_low`=0, the reset action wins: the chain is cleared and the output is low.
- R11: A falling edge of `cnt_in` driven between clocks changes the count at the third rising clock edge after it, not at the second. The internal strobe is one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| cnt_in | input | 1 | Count source, advances on falling edges |
| sel | input | 4 | Tap select code |
| skip_low | input | 1 | Skip the first eight stages |
| force_hi | input | 1 | Clear chain, latch output high |
| force_lo | input | 1 | Clear chain, output low |
| hold | input | 1 | Freeze the count |
| osc_stop | input | 1 | Block the count source |
| tap_out | output | 1 | Selected stage or latched level |

## Verification
A miscounted chain shows up at `tap_out` only when the selected stage flips. For that reason the bench sweeps every select code after each edge, so a wrong bit in stages 9 to 24 is visible within one edge. Errors in stages 1 to 8 cannot be seen directly. They show up at the rollover after test mode, where a single missing one stops the carry, and in the serial sweep within 256 edges. A wrong controller state shows within the first one or two edges after a set or reset release, as an output level that is high or low one edge too early or too late.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [2:0] {
        ST_CLEAR  = 3'd0,
        ST_FORCED = 3'd1,
        ST_WAKE   = 3'd2,
        ST_RUN    = 3'd3,
        ST_TEST   = 3'd4
    } tmr_state_e;
endpackage

// File: rtl/tap_edge_sync.sv
module tap_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_stb
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign fall_stb = s3_q & ~s2_q;
endmodule

// File: rtl/tap_sect_ctr.sv
module tap_sect_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + W'(1);
    end
endmodule

// File: rtl/tap_ctrl_fsm.sv
module tap_ctrl_fsm
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic rst_in,
    input  logic bypass,
    input  logic stb,
    input  logic tap_bit,
    output logic clr_chain,
    output logic run_en,
    output logic test_en,
    output logic tap_out
);
    tmr_state_e state_q, state_d;
    logic test_req;

    assign test_req = bypass & set_in & rst_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (test_req)    state_d = ST_TEST;
        else if (rst_in) state_d = ST_CLEAR;
        else if (set_in) state_d = ST_FORCED;
        else begin
            unique case (state_q)
                ST_CLEAR:  state_d = ST_RUN;
                ST_FORCED: state_d = ST_WAKE;
                ST_WAKE:   state_d = stb ? ST_RUN : ST_WAKE;
                ST_RUN:    state_d = ST_RUN;
                ST_TEST:   state_d = ST_RUN;
                default:   state_d = ST_CLEAR;
            endcase
        end
    end

    always_comb begin
        clr_chain = (set_in | rst_in) & ~(test_req & (state_q == ST_TEST));
        run_en    = 1'b0;
        test_en   = 1'b0;
        tap_out   = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                run_en  = stb & ~set_in & ~rst_in;
            end
            ST_FORCED, ST_WAKE: begin
                tap_out = 1'b1;
            end
            ST_RUN: begin
                run_en  = stb & ~set_in & ~rst_in;
                tap_out = tap_bit;
            end
            ST_TEST: begin
                test_en = stb & test_req;
            end
            default: tap_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/stage_tap_timer.sv
module stage_tap_timer #(
    parameter int STAGES = 24,
    parameter int SECT_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             skip_low,
    input  logic             force_hi,
    input  logic             force_lo,
    input  logic             hold,
    input  logic             osc_stop,
    output logic             tap_out
);
    localparam int NSECT    = STAGES / SECT_W;
    localparam int TAP_BASE = SECT_W;
    localparam int IDX_W    = $clog2(STAGES);

    logic              fall_raw, stb_g;
    logic              clr_chain, run_en, test_en, tap_bit;
    logic [NSECT-1:0]  sect_inc;
    logic [STAGES-1:0] chain;
    logic [IDX_W-1:0]  tap_idx;

    tap_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .din(cnt_in), .fall_stb(fall_raw)
    );

    assign stb_g = fall_raw & ~hold & ~osc_stop;

    genvar s;
    generate
        for (s = 0; s < NSECT; s++) begin : g_sect
            logic [SECT_W-1:0] q;
            if (s == 0) begin : g_first
                assign sect_inc[s] = test_en | (run_en & ~skip_low);
            end else if (s == 1) begin : g_entry
                assign sect_inc[s] = test_en |
                    (skip_low ? run_en : (sect_inc[0] & ~test_en & (&g_sect[0].q)));
            end else begin : g_rest
                assign sect_inc[s] = test_en |
                    (sect_inc[s-1] & ~test_en & (&g_sect[s-1].q));
            end
            tap_sect_ctr #(.W(SECT_W)) u_ctr (
                .clk(clk), .rst_n(rst_n), .clr(clr_chain),
                .inc(sect_inc[s]), .q(q)
            );
            assign chain[s*SECT_W +: SECT_W] = q;
        end
    endgenerate

    assign tap_idx = IDX_W'(TAP_BASE) + IDX_W'(sel);
    assign tap_bit = chain[tap_idx];

    tap_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .set_in(force_hi), .rst_in(force_lo),
        .bypass(skip_low), .stb(stb_g), .tap_bit(tap_bit),
        .clr_chain(clr_chain), .run_en(run_en), .test_en(test_en),
        .tap_out(tap_out)
    );
endmodule

// File: rtl/stage_tap_timer_chk.sv
module stage_tap_timer_chk #(
    parameter int STAGES = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              force_hi,
    input logic              force_lo,
    input logic              skip_low,
    input logic              hold,
    input logic              osc_stop,
    input logic              tap_out,
    input logic [STAGES-1:0] chain_q,
    input logic              fall_stb
);
    p_clear_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (force_lo && !(skip_low && force_hi)) |=> !tap_out);

    p_set_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hi && !force_lo) |=> tap_out);

    p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !force_hi && !force_lo) |=> $stable(chain_q));

    p_stop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !force_hi && !force_lo) |=> $stable(chain_q));

    p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_hi && !force_lo && !skip_low) |=>
        ((chain_q == $past(chain_q)) || (chain_q == $past(chain_q) + STAGES'(1))));

    p_strobe_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);

    p_prio_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hi && force_lo && !skip_low) |=> (chain_q == '0));
endmodule

bind stage_tap_timer stage_tap_timer_chk #(.STAGES(STAGES)) chk_i (
    .clk(clk), .rst_n(rst_n), .force_hi(force_hi), .force_lo(force_lo),
    .skip_low(skip_low), .hold(hold), .osc_stop(osc_stop),
    .tap_out(tap_out), .chain_q(chain), .fall_stb(fall_raw)
);

// File: tb/stage_tap_timer_tb.sv
`timescale 1ns/1ps
module stage_tap_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_in = 1'b1;
    logic [3:0] sel = '0;
    logic       skip_low = 1'b1;
    logic       force_hi = 1'b0;
    logic       force_lo = 1'b0;
    logic       hold = 1'b0;
    logic       osc_stop = 1'b0;
    logic       tap_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stage_tap_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .sel(sel),
        .skip_low(skip_low), .force_hi(force_hi), .force_lo(force_lo),
        .hold(hold), .osc_stop(osc_stop), .tap_out(tap_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        cnt_in = 1'b0; tick(4);
        cnt_in = 1'b1; tick(4);
    endtask

    task automatic sweep_hi(input string tag, input int n);
        for (int k = 0; k < 16; k++) begin
            sel = 4'(k); #0.1;
            check(tag, tap_out, 1'(n >> k));
        end
    endtask

    task automatic do_reset();
        force_lo = 1'b1; tick(2);
        force_lo = 1'b0; tick(2);
    endtask

    initial begin
        tick(3);
        check("R4 reset state", tap_out, 1'b0);
        rst_n = 1'b1; tick(2);

        // R3, R1: skip high divider sweep
        for (int n = 1; n <= 40; n++) begin
            pulse();
            sweep_hi("R3 skip-high tap", n);
        end

        // R4: mid-count clear
        force_lo = 1'b1; tick(2);
        sweep_hi("R4 cleared while low", 0);
        force_lo = 1'b0; tick(2);
        pulse();
        sweep_hi("R4 count restarts", 1);

        // R2, R1: skip low serial sweep
        do_reset();
        skip_low = 1'b0;
        for (int n = 1; n <= 1100; n++) begin
            pulse();
            for (int k = 0; k < 3; k++) begin
                sel = 4'(k); #0.1;
                check("R2 skip-low tap", tap_out, 1'(n >> (8 + k)));
            end
        end

        // R6: hold
        skip_low = 1'b1; do_reset();
        repeat (3) pulse();
        hold = 1'b1;
        repeat (5) pulse();
        sweep_hi("R6 held count", 3);
        hold = 1'b0;
        pulse();
        sweep_hi("R6 resume", 4);

        // R7: source stop
        osc_stop = 1'b1;
        repeat (4) pulse();
        sweep_hi("R7 stopped count", 4);
        osc_stop = 1'b0;
        pulse();
        sweep_hi("R7 resume", 5);

        // R5: set and two-edge restart
        sel = 4'd0;
        force_hi = 1'b1; tick(2);
        check("R5 forced high", tap_out, 1'b1);
        force_hi = 1'b0; tick(3);
        check("R5 high after release", tap_out, 1'b1);
        pulse();
        sweep_hi("R5 first edge low, no count", 0);
        pulse();
        sweep_hi("R5 second edge counts", 1);

        // R11: synchronizer latency and single count per level
        sel = 4'd0; #0.1;
        cnt_in = 1'b0;
        tick(2);
        check("R11 not yet after two edges", tap_out, 1'b1);
        tick(1);
        check("R11 counted at third edge", tap_out, 1'b0);
        tick(20);
        cnt_in = 1'b1; tick(4);
        sweep_hi("R11 long low counts once", 2);

        // R10: reset priority without skip
        skip_low = 1'b0;
        force_hi = 1'b1; force_lo = 1'b1; tick(2);
        check("R10 reset wins", tap_out, 1'b0);
        force_hi = 1'b0; force_lo = 1'b0; tick(2);
        check("R10 chain cleared", tap_out, 1'b0);

        // R8: test mode load
        skip_low = 1'b1;
        repeat (3) pulse();
        force_hi = 1'b1; force_lo = 1'b1; tick(2);
        check("R8 test output low", tap_out, 1'b0);
        repeat (255) pulse();
        check("R8 test output low after load", tap_out, 1'b0);
        force_hi = 1'b0; force_lo = 1'b0; tick(2);
        sweep_hi("R8 all ones skip high", 32'hFFFF);
        skip_low = 1'b0;
        sweep_hi("R8 all ones skip low", 32'hFFFF);

        // R9: rollover
        pulse();
        sweep_hi("R9 rollover to zero", 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule